// File: doc/BRIEF.md
# Searchable Writeback Queue Scoreboard

This block is a small in-order queue of pending writeback records for a single-issue pipeline. The execute side pushes one record per accepted instruction and the writeback side pops the oldest record. While the records wait, two independent combinational search ports each take a register index. Each port reports whether any queued record will still write that register. Execute ORs the two flags to decide whether to stall.

Each record has a kind, a register field and a data field. The kind encoding is 0 for an ALU result with data and a destination, 1 for a load with a destination only, 2 for a store, and 3 for a host operation whose small payload sits in the data field. Only ALU and load records claim their destination. Store and host records are invisible to searches.

A search sees the queue as it stood at the start of the cycle. A record pushed in the same cycle shows up one cycle later. A record popped in the same cycle still counts for that cycle.

Top module: `wbq_scoreboard`

## Requirements
- R1: A synchronous active-high reset `rst` empties the queue. After reset `empty`=1, `full`=0, and both hit outputs are 0 for every index.
- R2: A queued record of kind 0 (ALU) or kind 1 (load) whose register field equals a port's index drives that port's hit output to 1.
- R3: Records of kind 2 (store) and kind 3 (host) never cause a hit, whatever their register field holds and whatever index is queried.
- R4: Ports A and B are evaluated independently in the same cycle. Each hit output depends only on its own index.
- R5: Index 0 gets no special treatment. A queued ALU or load record with register field 0 produces a hit for a query of 0.
- R6: A record pushed in a cycle is not visible to a search in that cycle and is visible from the next cycle. A popped record stops hitting from the cycle after its pop.
- R7: Records leave in arrival order. Whenever `empty`=0, `first_kind`, `first_dest` and `first_data` show the oldest record.
- R8: `full` is 1 when DEPTH records are queued. A push while full is discarded and `enq_drop` is 1 in that cycle.
- R9: A pop while empty is discarded, `deq_drop` is 1 in that cycle, and the queue stays empty.
- R10: A push and a pop in the same cycle are both taken when the queue is neither full nor empty, and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Push request |
| enq_kind | input | 2 | Kind of pushed record (0 ALU, 1 load, 2 store, 3 host) |
| enq_dest | input | RW | Register field of pushed record |
| enq_data | input | DW | Data or host payload of pushed record |
| deq_valid | input | 1 | Pop request |
| first_kind | output | 2 | Kind of oldest record |
| first_dest | output | RW | Register field of oldest record |
| first_data | output | DW | Data field of oldest record |
| empty | output | 1 | Queue holds no record |
| full | output | 1 | Queue holds DEPTH records |
| enq_drop | output | 1 | Push refused because the queue is full |
| deq_drop | output | 1 | Pop refused because the queue is empty |
| qa_idx | input | RW | Search index, port A |
| qa_hit | output | 1 | A queued writer targets qa_idx |
| qb_idx | input | RW | Search index, port B |
| qb_hit | output | 1 | A queued writer targets qb_idx |

## Verification
The bench sends store and host records with the queried register in their register field. A design that matched on the register field alone would stall on them. It queries a freshly pushed index in the cycle of the push and in the cycle of a pop. A design that bypassed the push, or that dropped records early, would flip the hit one cycle too soon. Index 0 is queried against a pending load to 0, so a design that hardwired zero to no-hit would miss a real hazard. The bench also pushes into a full queue, pops an empty one, and runs random traffic against a record-queue model. This catches stale slots that still match after wrap-around and drops that corrupt the pointers.

// File: rtl/wbq_scoreboard.sv
module wbq_scoreboard #(
  parameter int DEPTH = 4,
  parameter int RW    = 5,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq_valid,
  input  logic [1:0]    enq_kind,
  input  logic [RW-1:0] enq_dest,
  input  logic [DW-1:0] enq_data,
  input  logic          deq_valid,
  output logic [1:0]    first_kind,
  output logic [RW-1:0] first_dest,
  output logic [DW-1:0] first_data,
  output logic          empty,
  output logic          full,
  output logic          enq_drop,
  output logic          deq_drop,
  input  logic [RW-1:0] qa_idx,
  output logic          qa_hit,
  input  logic [RW-1:0] qb_idx,
  output logic          qb_hit
);

  localparam logic [1:0] K_ALU  = 2'd0;
  localparam logic [1:0] K_LOAD = 2'd1;

  logic [1:0]       kind_q [DEPTH];
  logic [RW-1:0]    dest_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;
  logic [DEPTH-1:0] hit_a, hit_b;
  logic             do_enq, do_deq;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign do_enq   = enq_valid & ~full;
  assign do_deq   = deq_valid & ~empty;
  assign enq_drop = enq_valid & full;
  assign deq_drop = deq_valid & empty;

  always_ff @(posedge clk) begin
    if (do_enq) begin
      kind_q[wr_ptr] <= enq_kind;
      dest_q[wr_ptr] <= enq_dest;
      data_q[wr_ptr] <= enq_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_enq) begin
        vld_q[wr_ptr] <= 1'b1;
        wr_ptr        <= bump(wr_ptr);
      end
      if (do_deq) begin
        vld_q[rd_ptr] <= 1'b0;
        rd_ptr        <= bump(rd_ptr);
      end
      count <= count + CW'(do_enq) - CW'(do_deq);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic writer;
    assign writer   = vld_q[i] & ((kind_q[i] == K_ALU) | (kind_q[i] == K_LOAD));
    assign hit_a[i] = writer & (dest_q[i] == qa_idx);
    assign hit_b[i] = writer & (dest_q[i] == qb_idx);
  end

  assign qa_hit = |hit_a;
  assign qb_hit = |hit_b;

  assign first_kind = kind_q[rd_ptr];
  assign first_dest = dest_q[rd_ptr];
  assign first_data = data_q[rd_ptr];

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (empty && !full && vld_q == '0));

  p_hit_needs_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (qa_hit || qb_hit) |-> !empty);

  p_valid_count_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(vld_q) == 32'(count));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (full && enq_valid && !deq_valid) |=> (full && $stable(wr_ptr)));

  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    (empty && deq_valid) |=> $stable(rd_ptr));

  p_both_ops_r10: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && deq_valid && !empty && !full) |=> $stable(count));

endmodule

// File: tb/sim_wbq_scoreboard.sv
module sim_wbq_scoreboard;
  localparam int DEPTH = 4;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  dest;
    logic [31:0] data;
  } rec_t;

  logic clk = 1'b0, rst = 1'b1;
  logic enq_valid = 1'b0, deq_valid = 1'b0;
  logic [1:0] enq_kind = '0;
  logic [4:0] enq_dest = '0, qa_idx = '0, qb_idx = '0;
  logic [31:0] enq_data = '0;
  logic [1:0] first_kind;
  logic [4:0] first_dest;
  logic [31:0] first_data;
  logic empty, full, enq_drop, deq_drop, qa_hit, qb_hit;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  rec_t model[$];

  always #2 clk = ~clk;

  wbq_scoreboard #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_kind(enq_kind),
    .enq_dest(enq_dest), .enq_data(enq_data), .deq_valid(deq_valid),
    .first_kind(first_kind), .first_dest(first_dest), .first_data(first_data),
    .empty(empty), .full(full), .enq_drop(enq_drop), .deq_drop(deq_drop),
    .qa_idx(qa_idx), .qa_hit(qa_hit), .qb_idx(qb_idx), .qb_hit(qb_hit));

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic model_hit(input logic [4:0] idx);
    foreach (model[i])
      if (model[i].kind < 2'd2 && model[i].dest == idx) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input logic e, input logic [1:0] k, input logic [4:0] d,
                      input logic [31:0] v, input logic q,
                      input logic [4:0] a, input logic [4:0] b, input string tag);
    logic take_e, take_q;
    @(negedge clk);
    enq_valid = e; enq_kind = k; enq_dest = d; enq_data = v;
    deq_valid = q; qa_idx = a; qb_idx = b;
    #1;
    check(tag, "qa_hit", qa_hit, model_hit(a));
    check(tag, "qb_hit", qb_hit, model_hit(b));
    check(tag, "empty", empty, model.size() == 0);
    check(tag, "full", full, model.size() == DEPTH);
    check(tag, "enq_drop", enq_drop, e && model.size() == DEPTH);
    check(tag, "deq_drop", deq_drop, q && model.size() == 0);
    if (model.size() != 0) begin
      check(tag, "first_kind", first_kind, model[0].kind);
      check(tag, "first_dest", first_dest, model[0].dest);
      check(tag, "first_data", first_data, model[0].data);
    end
    take_e = e && model.size() < DEPTH;
    take_q = q && model.size() > 0;
    @(posedge clk);
    if (take_q) void'(model.pop_front());
    if (take_e) model.push_back('{kind: k, dest: d, data: v});
  endtask

  task automatic idle(input logic [4:0] a, input logic [4:0] b, input string tag);
    step(1'b0, 2'd0, 5'd0, 32'd0, 1'b0, a, b, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    idle(5'd0, 5'd31, "R1");
    // R6: push ALU to r5, same-cycle query misses, next cycle hits (R2)
    step(1'b1, 2'd0, 5'd5, 32'hCAFE0005, 1'b0, 5'd5, 5'd7, "R6");
    idle(5'd5, 5'd7, "R2");
    // R4: ports independent
    idle(5'd7, 5'd5, "R4");
    // R3: store and host naming r7 never hit
    step(1'b1, 2'd2, 5'd7, 32'h0, 1'b0, 5'd7, 5'd7, "R3");
    step(1'b1, 2'd3, 5'd7, 32'h000000A5, 1'b0, 5'd7, 5'd7, "R3");
    idle(5'd7, 5'd5, "R3");
    // R5: load to r0 hits for index 0; queue now full (R8)
    step(1'b1, 2'd1, 5'd0, 32'h0, 1'b0, 5'd0, 5'd1, "R5");
    idle(5'd0, 5'd5, "R5");
    // R8: push while full is dropped, contents intact
    step(1'b1, 2'd0, 5'd9, 32'h99, 1'b0, 5'd9, 5'd9, "R8");
    idle(5'd9, 5'd5, "R8");
    // R10: at full, pop taken and push dropped; then both while partly full
    step(1'b1, 2'd0, 5'd9, 32'h99, 1'b1, 5'd5, 5'd9, "R10");
    // R6: popped r5 record gone
    idle(5'd5, 5'd9, "R6");
    step(1'b1, 2'd0, 5'd12, 32'h12, 1'b1, 5'd12, 5'd0, "R10");
    idle(5'd12, 5'd0, "R10");
    // R7: drain in order
    for (int i = 0; i < 4; i++) step(1'b0, 2'd0, 5'd0, 32'd0, 1'b1, 5'd12, 5'd0, "R7");
    // R9: pop while empty
    step(1'b0, 2'd0, 5'd0, 32'd0, 1'b1, 5'd0, 5'd12, "R9");
    idle(5'd0, 5'd12, "R9");
    // random traffic
    for (int n = 0; n < 3000; n++)
      step(1'($urandom_range(0, 99) < 55), 2'($urandom), 5'($urandom_range(0, 7)),
           $urandom, 1'($urandom_range(0, 99) < 50),
           5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), "R2");
    // R1: reset mid-traffic empties the queue
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    model.delete();
    @(negedge clk); rst = 1'b0;
    idle(5'd0, 5'd3, "R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule